// File: doc/BRIEF.md
# Digital Soft-Start Sequencer

This block produces the startup reference of a voltage-mode buck regulator as a stepped digital code, and it runs the startup sequence from enable to the end of soft start. Once the supply power-on-reset is good and the enable comparator reports the compensation node above its threshold, the block waits for the compensation clamp. It then raises the step code by one every `STEP_CYCLES` clocks. A DAC outside this block turns the code into the soft-start voltage.

The regulation reference sits at step `REF_STEPS`. When the ramp gets there, a select output passes control of the error amplifier to the fixed reference. The ramp keeps climbing to a much higher ceiling (`CEIL_STEPS`). Soft start is declared done only at that ceiling. At the first high-side pulse of a ramp, the block samples the phase comparator. If phase is not above 2 V, the input supply is taken as absent. The block then raises a hiccup flag, lets the ramp run through its full length and starts a fresh soft start. Losing enable or power-on-reset returns the block to idle at once.

The step period is `CLK_MHZ * RAMP_US / REF_STEPS` clocks. With the defaults (10 MHz, 2000 us, 100 steps) that is 200 clocks per step.

Top module: `ss_sequencer`

## Requirements
- R1: While `por_ok` is low (and during reset), `ss_code` is 0 and `ref_sel`, `ss_done` and `vin_hiccup` are all 0.
- R2: With `por_ok` high and `en_cmp` low, the block stays idle with all outputs 0. Startup begins only when both are high.
- R3: After enabling, `ss_code` holds at 0 until `comp_at_clamp` is seen high. The clock edge that sees it starts the ramp, and code 1 appears `STEP_CYCLES` clocks after that edge.
- R4: During a ramp, `ss_code` rises by exactly 1 every `STEP_CYCLES` clocks, where `STEP_CYCLES = CLK_MHZ*RAMP_US/REF_STEPS`. It never changes by any amount other than +1, except when it returns to 0.
- R5: `ref_sel` is 1 (fixed reference drives the amplifier) exactly when `ss_code >= REF_STEPS`, and 0 (ramp drives) otherwise.
- R6: The code continues past `REF_STEPS` up to `CEIL_STEPS`. `ss_done` rises in the same clock that the code reaches `CEIL_STEPS`, and both then hold.
- R7: If the first `hs_first_pulse` of a ramp is seen with `phase_hi` = 0, `vin_hiccup` is 1 from the next clock. The ramp keeps stepping, and `ss_done` is never asserted in this ramp.
- R8: Only the first `hs_first_pulse` of a ramp is sampled. Later pulses in the same ramp, even with `phase_hi` = 0, have no effect.
- R9: In hiccup, at the clock where the code would reach `CEIL_STEPS` it returns to 0 and `vin_hiccup` clears. The next clock starts a new ramp if `comp_at_clamp` is high, so code 1 appears `STEP_CYCLES + 1` clocks after the return to 0.
- R10: When `en_cmp` or `por_ok` drops at any time, the next clock shows `ss_code` = 0 with `ss_done` and `vin_hiccup` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply power-on-reset good |
| en_cmp | input | 1 | Enable comparator: compensation node above enable threshold |
| comp_at_clamp | input | 1 | Compensation node has reached its clamp level |
| phase_hi | input | 1 | Phase node above 2 V comparator |
| hs_first_pulse | input | 1 | One-clock strobe at a high-side turn-on |
| ss_code | output | CODE_W (10) | Soft-start step code to the DAC |
| ref_sel | output | 1 | 1: fixed reference drives the error amplifier; 0: ramp drives it |
| ss_done | output | 1 | Soft start complete; undervoltage monitoring may start |
| vin_hiccup | output | 1 | Input supply found absent; hiccup ramp in progress |

## Verification
On every cycle, the assertions check the following:
- the code only steps by one or returns to zero;
- the select bit rises exactly as the code reaches the reference step;
- done appears only at the ceiling and only after the final step;
- a hiccup starts only after a strobe that saw phase low;
- a dropped enable or power-on-reset clears the outputs.

Only the bench scenarios can show the absolute step timing, the hold while waiting for the clamp, and that a later strobe in the same ramp is ignored. They also show that a hiccup ramp really runs its full length and is followed by a fresh ramp.

// File: rtl/ss_seq_pkg.sv
`timescale 1ns/1ps
package ss_seq_pkg;

    typedef enum logic [2:0] {
        SS_IDLE   = 3'd0,
        SS_ARM    = 3'd1,
        SS_RAMP   = 3'd2,
        SS_DONE   = 3'd3,
        SS_HICCUP = 3'd4
    } ss_state_e;

endpackage

// File: rtl/ss_step_timer.sv
`timescale 1ns/1ps
// Prescaler that emits one tick every STEP_CYCLES clocks while run_i is high.
module ss_step_timer #(
    parameter int STEP_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int TMR_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(STEP_CYCLES - 1);

    logic [TMR_W-1:0] timer_d, timer_q;

    assign tick_o = run_i && (timer_q == LAST);

    always_comb begin
        timer_d = timer_q;
        if (!run_i || tick_o) begin
            timer_d = '0;
        end else begin
            timer_d = timer_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else begin
            timer_q <= timer_d;
        end
    end

    // R4: the count never runs past the step period
    assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q <= LAST);

    generate
        if (STEP_CYCLES > 1) begin : g_gap
            // R4: ticks are spaced, never back to back
            assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/ss_vin_probe.sv
`timescale 1ns/1ps
// Samples the phase comparator on the first high-side strobe of an armed ramp.
module ss_vin_probe (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic strobe_i,
    input  logic phase_hi_i,
    output logic missing_o
);
    logic seen_d, seen_q;

    assign missing_o = arm_i && strobe_i && !seen_q && !phase_hi_i;

    always_comb begin
        seen_d = seen_q;
        if (!arm_i) begin
            seen_d = 1'b0;
        end else if (strobe_i) begin
            seen_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end

endmodule

// File: rtl/ss_sequencer.sv
`timescale 1ns/1ps
module ss_sequencer #(
    parameter int CLK_MHZ    = 10,
    parameter int RAMP_US    = 2000,
    parameter int REF_STEPS  = 100,
    parameter int CEIL_STEPS = 700,
    parameter int CODE_W     = $clog2(CEIL_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              en_cmp,
    input  logic              comp_at_clamp,
    input  logic              phase_hi,
    input  logic              hs_first_pulse,
    output logic [CODE_W-1:0] ss_code,
    output logic              ref_sel,
    output logic              ss_done,
    output logic              vin_hiccup
);
    import ss_seq_pkg::*;

    localparam int STEP_CYCLES = (CLK_MHZ * RAMP_US) / REF_STEPS;
    localparam logic [CODE_W-1:0] CODE_REF  = CODE_W'(REF_STEPS);
    localparam logic [CODE_W-1:0] CODE_CEIL = CODE_W'(CEIL_STEPS);
    localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(CEIL_STEPS - 1);

    typedef struct packed {
        ss_state_e         state;
        logic [CODE_W-1:0] code;
    } seq_t;

    seq_t seq_d, seq_q;
    logic step_tick;
    logic vin_missing;
    logic timer_run;
    logic probe_arm;

    assign timer_run = (seq_q.state == SS_RAMP) || (seq_q.state == SS_HICCUP);
    assign probe_arm = (seq_q.state == SS_RAMP);

    ss_step_timer #(
        .STEP_CYCLES (STEP_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (timer_run),
        .tick_o (step_tick)
    );

    ss_vin_probe u_probe (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (probe_arm),
        .strobe_i   (hs_first_pulse),
        .phase_hi_i (phase_hi),
        .missing_o  (vin_missing)
    );

    always_comb begin
        seq_d = seq_q;
        if (!por_ok || !en_cmp) begin
            seq_d.state = SS_IDLE;
            seq_d.code  = '0;
        end else begin
            unique case (seq_q.state)
                SS_IDLE: begin
                    seq_d.state = SS_ARM;
                    seq_d.code  = '0;
                end
                SS_ARM: begin
                    if (comp_at_clamp) begin
                        seq_d.state = SS_RAMP;
                    end
                end
                SS_RAMP: begin
                    if (step_tick) begin
                        seq_d.code = seq_q.code + CODE_W'(1);
                    end
                    if (vin_missing) begin
                        seq_d.state = SS_HICCUP;
                    end else if (step_tick && (seq_q.code == CODE_LAST)) begin
                        seq_d.state = SS_DONE;
                    end
                end
                SS_HICCUP: begin
                    if (seq_q.code >= CODE_LAST && (step_tick || seq_q.code == CODE_CEIL)) begin
                        seq_d.state = SS_ARM;
                        seq_d.code  = '0;
                    end else if (step_tick) begin
                        seq_d.code = seq_q.code + CODE_W'(1);
                    end
                end
                SS_DONE: begin
                    seq_d = seq_q;
                end
                default: begin
                    seq_d.state = SS_IDLE;
                    seq_d.code  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SS_IDLE, code: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ss_code    = seq_q.code;
    assign ref_sel    = (seq_q.code >= CODE_REF);
    assign ss_done    = (seq_q.state == SS_DONE);
    assign vin_hiccup = (seq_q.state == SS_HICCUP);

    // R4: the code only advances by one or falls back to zero
    assert_code_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ss_code) |-> (ss_code == $past(ss_code) + CODE_W'(1)) || (ss_code == '0));

    // R5: the reference takes over exactly as the ramp reaches it
    assert_takeover_point_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_sel) |-> ss_code == CODE_REF);

    // R6: done only at the ceiling, entered from the final step
    assert_done_at_ceil_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> ss_code == CODE_CEIL);
    assert_done_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_done) |-> $past(ss_code) == CODE_LAST);

    // R7: a hiccup starts only after a strobe that saw phase low
    assert_hiccup_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vin_hiccup) |-> $past(hs_first_pulse) && !$past(phase_hi));

    // R1: power-on-reset low clears everything
    assert_por_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (ss_code == '0) && !ss_done && !vin_hiccup);

    // R10: enable low clears the code on the next clock
    assert_en_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_cmp |=> (ss_code == '0) && !ss_done && !vin_hiccup);

endmodule

// File: tb/tb_ss_sequencer.sv
`timescale 1ns/1ps
module tb_ss_sequencer;

    localparam int CLK_MHZ = 2;
    localparam int RAMP_US = 200;
    localparam int REF     = 100;
    localparam int CEIL    = 700;
    localparam int S       = CLK_MHZ * RAMP_US / REF;
    localparam int CW      = $clog2(CEIL + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic por_ok = 1'b0, en_cmp = 1'b0, comp_at_clamp = 1'b0;
    logic phase_hi = 1'b0, hs_first_pulse = 1'b0;
    logic [CW-1:0] ss_code;
    logic ref_sel, ss_done, vin_hiccup;

    int n_tests = 0;
    int n_fail  = 0;

    ss_sequencer #(
        .CLK_MHZ    (CLK_MHZ),
        .RAMP_US    (RAMP_US),
        .REF_STEPS  (REF),
        .CEIL_STEPS (CEIL)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .por_ok         (por_ok),
        .en_cmp         (en_cmp),
        .comp_at_clamp  (comp_at_clamp),
        .phase_hi       (phase_hi),
        .hs_first_pulse (hs_first_pulse),
        .ss_code        (ss_code),
        .ref_sel        (ref_sel),
        .ss_done        (ss_done),
        .vin_hiccup     (vin_hiccup)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_idle(input string tag);
        chk(ss_code == 0, {tag, " code"}, ss_code, 0);
        chk(ref_sel == 0, {tag, " ref_sel"}, ref_sel, 0);
        chk(ss_done == 0, {tag, " done"}, ss_done, 0);
        chk(vin_hiccup == 0, {tag, " hiccup"}, vin_hiccup, 0);
    endtask

    // Expected code n clocks after enable+clamp were driven together.
    function automatic int exp_code(input int n, input bit abort);
        int c;
        if (abort && n >= 2 + CEIL * S) begin
            c = (n - 3 - CEIL * S < 0) ? 0 : (n - 3 - CEIL * S) / S;
        end else begin
            c = (n < 2) ? 0 : (n - 2) / S;
            if (c > CEIL) c = CEIL;
        end
        return c;
    endfunction

    task automatic teardown();
        hs_first_pulse = 1'b0;
        phase_hi = 1'b0;
        en_cmp = 1'b0;
        comp_at_clamp = 1'b0;
        por_ok = 1'b1;
        step();
        step();
    endtask

    task automatic ramp_run(input int strobe_step, input bit phase_val,
                            input int drop_n, input bit drop_por);
        bit abort = !phase_val;
        int ns = -1;
        bit strobed = 1'b0;
        bit second = 1'b0;
        int ab_end = 2 + CEIL * S;
        int endn;
        endn = (drop_n > 0) ? drop_n + 3 : (abort ? 3 + CEIL * S + 5 * S : ab_end + 10);
        por_ok = 1'b1;
        en_cmp = 1'b1;
        comp_at_clamp = 1'b1;
        for (int n = 1; n <= endn; n++) begin
            int c;
            bit r, d, h;
            string tc;
            step();
            hs_first_pulse = 1'b0;
            phase_hi = 1'b0;
            if (drop_n > 0 && n > drop_n) begin
                c = 0; r = 0; d = 0; h = 0;
                tc = "R10 drop";
            end else begin
                c = exp_code(n, abort && ns >= 0);
                r = (c >= REF);
                h = abort && ns >= 0 && n > ns && n < ab_end;
                d = !abort && c == CEIL;
                tc = (n <= 2 + S) ? "R3 first step" : ((n >= ab_end && abort) ? "R9 restart" : "R4 step code");
            end
            chk(ss_code == c, tc, ss_code, c);
            chk(ref_sel == r, "R5 ref_sel", ref_sel, r);
            chk(ss_done == d, "R6 done", ss_done, d);
            chk(vin_hiccup == h, second ? "R8 later strobe ignored" : "R7 hiccup", vin_hiccup, h);
            if (!strobed && n >= 2 && c == strobe_step && !(drop_n > 0 && n >= drop_n)) begin
                hs_first_pulse = 1'b1;
                phase_hi = phase_val;
                strobed = 1'b1;
                ns = n;
            end else if (strobed && !second && !abort && c == strobe_step + 2) begin
                hs_first_pulse = 1'b1;
                phase_hi = 1'b0;
                second = 1'b1;
            end
            if (drop_n > 0 && n == drop_n) begin
                if (drop_por) por_ok = 1'b0;
                else en_cmp = 1'b0;
            end
        end
        teardown();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        int cnt;
        seed = $urandom(32'd4242);

        // Reset state (R1)
        step();
        chk_idle("R1 reset");
        step();
        rst_n = 1'b1;
        step();

        // R1: power-on-reset low blocks everything
        en_cmp = 1'b1;
        comp_at_clamp = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            chk_idle("R1 por low");
        end
        teardown();

        // R2: enable low keeps the block idle
        por_ok = 1'b1;
        comp_at_clamp = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            chk_idle("R2 enable low");
        end
        teardown();

        // R3: hold at zero until the clamp is reached, then first step timing
        por_ok = 1'b1;
        en_cmp = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step();
            chk_idle("R3 wait clamp");
        end
        comp_at_clamp = 1'b1;
        cnt = 0;
        while (ss_code == 0 && cnt < 10 * S) begin
            step();
            cnt++;
        end
        chk(cnt == S + 1, "R3 clocks to first step", cnt, S + 1);
        teardown();

        // Directed: full good ramp with an ignored later strobe (R4-R6, R8)
        ramp_run(5, 1'b1, 0, 1'b0);
        // Directed: absent input at the first pulse, hiccup then restart (R7, R9)
        ramp_run(10, 1'b0, 0, 1'b0);
        // Directed: strobe just before the reference, absent input
        ramp_run(REF - 1, 1'b0, 0, 1'b0);
        // Directed: enable drop mid-ramp and power-on-reset drop after done (R10)
        ramp_run(3, 1'b1, 1500, 1'b0);
        ramp_run(3, 1'b1, 2 + CEIL * S + 4, 1'b1);

        // Constrained random trials
        for (int t = 0; t < 4; t++) begin
            int sstep = 1 + int'($urandom % (CEIL - 4));
            bit pv = 1'($urandom % 2);
            int dn = ($urandom % 3 == 0) ? 20 + int'($urandom % 2000) : 0;
            bit dp = 1'($urandom % 2);
            ramp_run(sstep, pv, dn, dp);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule